// File: doc/BRIEF.md
# Instruction Predecode Fill Unit

This block sits on the refill path of an instruction cache. Each 32-bit instruction word that arrives from memory after a miss passes through it once. It leaves as a 36-bit predecoded word, and the cache stores that word in place of the raw instruction. Four added bits name the execution unit class that will run the instruction. A branch therefore shows up as soon as the word is read back from the cache, before full decode.

The unit also rewrites each word so that the decode stage has no field hunting to do. The destination register, first source and second source always sit in the same three 5-bit slots. This holds whatever the original format, and the move is a pure rearrangement, so no bit is lost. The top opcode bit is replaced by a flag that marks a floating-point destination. The other five opcode bits pass through. Together with the class field, they still identify the original opcode exactly.

Words enter on a valid/ready stream and leave on a second valid/ready stream. One word is accepted per cycle and the result appears one cycle later. The output register holds its word while the consumer stalls.

Top module: `pdf_fill_unit`

## Requirements
- R1: A synchronous reset clears `out_valid` on the next clock edge, even when a word is waiting. After reset, with the output idle, `in_ready` is 1.
- R2: A word accepted on an edge (`in_valid` and `in_ready` both 1) is on `out_word` with `out_valid` 1 right after that edge. With `out_ready` held at 1, a new word is accepted every cycle.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_word` and `out_valid` hold their values and `in_ready` is 0. The input word offered during the stall is taken once `out_ready` returns to 1.
- R4: The class field `out_word[35:32]` is set by the group `g = in_instr[31:29]`: g=000 or 001 gives 0 (integer ALU); 010 gives 1 (load/store); 011 gives 2 (branch); 100 gives 3 (floating point); 101 gives 4 (multiply/divide); 110 or 111 gives 15 (illegal).
- R5: `out_word[31]` is the floating-point destination flag, and `out_word[30:26]` equals `in_instr[30:26]`. The flag is 1 for group 100. It is also 1 for a load (group 010 with `in_instr[28]`=0) when `in_instr[26]`=1. In every other case it is 0.
- R6: `out_word[25:0]` equals `in_instr[25:0]` in these groups: 000, 001, loads (010 with bit 28 = 0), jumps (011 with bit 28 = 1), 110 and 111.
- R7: Stores (group 010 with `in_instr[28]`=1) map as follows: `out[25:21]`=`in[15:11]`, `out[20:16]`=`in[20:16]` (base), `out[15:11]`=`in[25:21]` (store data), `out[10:0]`=`in[10:0]`.
- R8: Conditional branches (group 011 with `in_instr[28]`=0) and floating-point group 100 map as follows: `out[25:21]`=`in[15:11]`, `out[20:16]`=`in[25:21]`, `out[15:11]`=`in[20:16]`, `out[10:0]`=`in[10:0]`.
- R9: Multiply/divide group 101 maps as follows: `out[25:21]`=`in[10:6]` (destination), `out[20:16]`=`in[25:21]`, `out[15:11]`=`in[20:16]`, `out[10:6]`=`in[15:11]`, `out[5:0]`=`in[5:0]`.
- R10: When no word is accepted on an edge and `out_ready` is 1, `out_valid` is 0 after that edge. An idle input never produces an output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Refill word is present |
| in_ready | output | 1 | Unit can take a refill word this cycle |
| in_instr | input | 32 | Raw instruction word from memory |
| out_valid | output | 1 | Predecoded word is present |
| out_ready | input | 1 | Cache fill side takes the word |
| out_word | output | 36 | Predecoded word: class, flag, opcode bits, normalised fields |

## Verification
A wrong permutation select or a wrong class decode has no hidden state to hide behind. It appears on `out_word` in the very cycle after the bad instruction is accepted, so one vector per format is enough to expose it. A fault in the valid register shows up in one of two ways, again one edge after the triggering event. Either a word is lost or duplicated during a stall, or a phantom word appears after an idle input. For that reason the stall release and the bubble after a stream are checked on the exact following cycle.

// File: rtl/pdf_pkg.sv
package pdf_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int CLASS_W = 4;
  localparam int REG_W   = 5;
  localparam int GRP_W   = 3;
  localparam int SLOT_N  = 4;
  localparam int PL_W    = INSTR_W - OP_W;
  localparam int LOW_W   = PL_W - SLOT_N * REG_W;
  localparam int PD_W    = INSTR_W + CLASS_W;
  localparam int SUB_HI_BIT = PL_W + 2;
  localparam int SUB_LO_BIT = PL_W;

  localparam logic [GRP_W-1:0] GRP_ALU_R = 3'b000;
  localparam logic [GRP_W-1:0] GRP_ALU_I = 3'b001;
  localparam logic [GRP_W-1:0] GRP_MEM   = 3'b010;
  localparam logic [GRP_W-1:0] GRP_CTL   = 3'b011;
  localparam logic [GRP_W-1:0] GRP_FPU   = 3'b100;
  localparam logic [GRP_W-1:0] GRP_MDU   = 3'b101;

  typedef enum logic [CLASS_W-1:0] {
    UC_ALU = 4'd0,
    UC_MEM = 4'd1,
    UC_BR  = 4'd2,
    UC_FP  = 4'd3,
    UC_MD  = 4'd4,
    UC_ILL = 4'd15
  } unit_class_e;

  typedef enum logic [1:0] {
    PM_KEEP  = 2'd0,
    PM_STORE = 2'd1,
    PM_ROT   = 2'd2,
    PM_MD    = 2'd3
  } perm_e;

  typedef struct packed {
    unit_class_e cls;
    logic        fp_dest;
    perm_e       perm;
  } pd_ctrl_t;
endpackage

// File: rtl/pdf_classify.sv
module pdf_classify
  import pdf_pkg::*;
(
  input  logic [GRP_W-1:0] grp,
  input  logic             sub_hi,
  input  logic             sub_lo,
  output pd_ctrl_t         ctrl
);
  always_comb begin
    ctrl.cls     = UC_ILL;
    ctrl.fp_dest = 1'b0;
    ctrl.perm    = PM_KEEP;
    case (grp)
      GRP_ALU_R, GRP_ALU_I: ctrl.cls = UC_ALU;
      GRP_MEM: begin
        ctrl.cls = UC_MEM;
        if (sub_hi) ctrl.perm = PM_STORE;
        else        ctrl.fp_dest = sub_lo;
      end
      GRP_CTL: begin
        ctrl.cls = UC_BR;
        if (!sub_hi) ctrl.perm = PM_ROT;
      end
      GRP_FPU: begin
        ctrl.cls     = UC_FP;
        ctrl.fp_dest = 1'b1;
        ctrl.perm    = PM_ROT;
      end
      GRP_MDU: begin
        ctrl.cls  = UC_MD;
        ctrl.perm = PM_MD;
      end
      default: ctrl.cls = UC_ILL;
    endcase
  end
endmodule

// File: rtl/pdf_field_mux.sv
module pdf_field_mux
  import pdf_pkg::*;
(
  input  perm_e           perm,
  input  logic [PL_W-1:0] payload,
  output logic [PL_W-1:0] norm
);
  logic [REG_W-1:0] slot [SLOT_N];
  logic [LOW_W-1:0] low;

  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
    assign slot[g] = payload[PL_W-1-g*REG_W -: REG_W];
  end
  assign low = payload[LOW_W-1:0];

  // slot 0 = bits 25:21, 1 = 20:16, 2 = 15:11, 3 = 10:6
  always_comb begin
    case (perm)
      PM_STORE: norm = {slot[2], slot[1], slot[0], slot[3], low};
      PM_ROT:   norm = {slot[2], slot[0], slot[1], slot[3], low};
      PM_MD:    norm = {slot[3], slot[0], slot[1], slot[2], low};
      default:  norm = payload;
    endcase
  end
endmodule

// File: rtl/pdf_out_stage.sv
module pdf_out_stage #(
  parameter int WIDTH = 36
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end
endmodule

// File: rtl/pdf_fill_unit.sv
module pdf_fill_unit
  import pdf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PD_W-1:0]    out_word
);
  pd_ctrl_t        ctrl;
  logic [PL_W-1:0] norm;
  logic [PD_W-1:0] pd_word;

  pdf_classify u_cls (
    .grp    (in_instr[INSTR_W-1 -: GRP_W]),
    .sub_hi (in_instr[SUB_HI_BIT]),
    .sub_lo (in_instr[SUB_LO_BIT]),
    .ctrl   (ctrl)
  );

  pdf_field_mux u_mux (
    .perm    (ctrl.perm),
    .payload (in_instr[PL_W-1:0]),
    .norm    (norm)
  );

  // top opcode bit is replaced by the floating-point destination flag
  assign pd_word = {ctrl.cls, ctrl.fp_dest, in_instr[INSTR_W-2 -: OP_W-1], norm};

  pdf_out_stage #(.WIDTH(PD_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pd_word),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_word)
  );
endmodule

// File: rtl/pdf_fill_unit_chk.sv
module pdf_fill_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_instr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [35:0] out_word
);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    rst |=> !out_valid);

  a_r2_accept_to_output: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  a_r3_hold_word: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  a_r10_bubble_drain: assert property (@(posedge clk) disable iff (rst)
    !in_valid && out_ready |=> !out_valid);

  a_r4_class_known: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_word[35:32] <= 4'd4 || out_word[35:32] == 4'd15));

  a_r5_fp_flag_class: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_word[31] |-> (out_word[35:32] == 4'd1 || out_word[35:32] == 4'd3));

  a_r8_fp_src_slot: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && in_instr[31:29] == 3'b100 |=>
      out_word[35:32] == 4'd3 && out_word[20:16] == $past(in_instr[25:21]));
endmodule

bind pdf_fill_unit pdf_fill_unit_chk chk_i (.*);

// File: tb/pdf_fill_unit_tb_top.sv
module pdf_fill_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pdf_fill_unit dut_i (.*);

  localparam int NV = 12;
  // {instruction, expected predecoded word}
  localparam logic [67:0] VEC [NV] = '{
    {{6'b000010, 5'd3, 5'd4, 5'd5, 11'h123},        {4'd0, 1'b0, 5'b00010, 5'd3, 5'd4, 5'd5, 11'h123}},         // R4 R6 alu reg
    {{6'b001101, 5'd7, 5'd8, 16'hBEEF},             {4'd0, 1'b0, 5'b01101, 5'd7, 5'd8, 16'hBEEF}},              // R6 alu imm
    {{6'b010000, 5'd9, 5'd10, 16'h0040},            {4'd1, 1'b0, 5'b10000, 5'd9, 5'd10, 16'h0040}},             // R6 int load
    {{6'b010001, 5'd11, 5'd12, 16'h0008},           {4'd1, 1'b1, 5'b10001, 5'd11, 5'd12, 16'h0008}},            // R5 fp load
    {{6'b010100, 5'd13, 5'd14, 5'd2, 11'h055},      {4'd1, 1'b0, 5'b10100, 5'd2, 5'd14, 5'd13, 11'h055}},       // R7 store
    {{6'b010101, 5'd1, 5'd2, 5'd3, 11'h7FF},        {4'd1, 1'b0, 5'b10101, 5'd3, 5'd2, 5'd1, 11'h7FF}},         // R7 R5 store, no flag
    {{6'b011000, 5'd5, 5'd6, 5'd31, 11'h001},       {4'd2, 1'b0, 5'b11000, 5'd31, 5'd5, 5'd6, 11'h001}},        // R8 cond branch
    {{6'b011100, 26'h2ABCDEF},                      {4'd2, 1'b0, 5'b11100, 26'h2ABCDEF}},                       // R6 jump
    {{6'b100011, 5'd17, 5'd18, 5'd19, 11'h3C0},     {4'd3, 1'b1, 5'b00011, 5'd19, 5'd17, 5'd18, 11'h3C0}},      // R8 R5 fp
    {{6'b101001, 5'd20, 5'd21, 5'd22, 5'd23, 6'h2A},{4'd4, 1'b0, 5'b01001, 5'd23, 5'd20, 5'd21, 5'd22, 6'h2A}}, // R9 muldiv
    {{6'b110000, 26'h3FFFFFF},                      {4'd15, 1'b0, 5'b10000, 26'h3FFFFFF}},                      // R4 illegal
    {{6'b111111, 26'h0000001},                      {4'd15, 1'b0, 5'b11111, 26'h0000001}}                       // R4 illegal
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {35'd0, out_valid}, 36'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle in_ready", {35'd0, in_ready}, 36'd1);
    chk("R10 idle no output", {35'd0, out_valid}, 36'd0);

    // table walk, back to back with out_ready high (R2, R4..R9)
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R2 out_valid streaming", {35'd0, out_valid}, 36'd1);
        chk("R2 in_ready streaming", {35'd0, in_ready}, 36'd1);
        chk("R4-class R5 R6 R7 R8 R9 word", out_word, VEC[i-1][35:0]);
      end
      if (i < NV) begin
        in_valid = 1'b1;
        in_instr = VEC[i][67:36];
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    chk("R10 drained after stream", {35'd0, out_valid}, 36'd0);

    // stall: R3
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_instr  = VEC[4][67:36];
    @(negedge clk);
    chk("R3 stall word A", out_word, VEC[4][35:0]);
    chk("R3 stall in_ready low", {35'd0, in_ready}, 36'd0);
    in_instr = VEC[9][67:36];
    @(negedge clk);
    chk("R3 held word A", out_word, VEC[4][35:0]);
    chk("R3 held valid", {35'd0, out_valid}, 36'd1);
    out_ready = 1'b1;
    @(negedge clk);
    chk("R3 word B after release", out_word, VEC[9][35:0]);
    chk("R3 valid after release", {35'd0, out_valid}, 36'd1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 bubble after release", {35'd0, out_valid}, 36'd0);

    // idle while consumer stalled: R10
    out_ready = 1'b0;
    @(negedge clk);
    chk("R10 no phantom word", {35'd0, out_valid}, 36'd0);

    // reset with a word waiting: R1
    in_valid = 1'b1;
    in_instr = VEC[8][67:36];
    @(negedge clk);
    chk("R8 fp word before reset", out_word, VEC[8][35:0]);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset drops waiting word", {35'd0, out_valid}, 36'd0);
    rst = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R1 in_ready after reset", {35'd0, in_ready}, 36'd1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule